// File: doc/BRIEF.md
# Memory-Operation Peephole Rewriter

This unit sits in an instruction stream between fetch and issue. It looks at each pair of directly adjacent register-indirect memory instructions and removes memory traffic that is redundant. It compares only the address register number of the two instructions and never a computed address. A load that reads through the same address register as the store or load just before it is turned into a register-to-register move. A store that is at once overwritten by a second store through the same address register is discarded. A per-instruction I/O flag turns all of this off for that pair.

Both sides use valid/ready streams of decoded instructions. The unit holds one instruction at most. A held load or store waits for its successor, because the successor decides whether the held instruction is released, deleted, or paired with a rewrite. Any other held instruction leaves as soon as the output is ready. A flush input drains the held instruction without accepting new input. Rewritten moves keep the sequence tag of the load they replace, and the output order is always the input order minus the deleted stores.

Instruction fields: a 2-bit opcode (00 other, 01 load, 10 store, 11 move), a data register field, an address register field, an I/O flag and a sequence tag. A load writes its data register from memory at the address in its address register. A store writes its data register to that address. For a move, the data register field is the destination and the address register field is the source.

Top module: `memop_peephole`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: A store (op 10, data Ra, address Rb) directly followed by a load (op 01, data Rc, address Rb) is emitted as the unchanged store followed by a move (op 11) with data field Rc, address field Ra and I/O flag 0.
- R3: A load (data Ra, address Rb) directly followed by a load (data Rc, address Rb) is emitted as the unchanged first load followed by a move with data field Rc and address field Ra.
- R4: In the load-load case, if the first load's data register equals Rb, both loads are emitted unchanged.
- R5: Two directly adjacent stores through the same address register emit only the second store.
- R6: If either instruction of a pair has its I/O flag set, no rewrite or deletion happens and both are emitted unchanged.
- R7: Pairs with different address registers, and pairs where either instruction is not a load or store (op 00 or 11), are emitted unchanged.
- R8: A held load or store is not emitted until the next instruction arrives or flush is high. A held op 00 or op 11 instruction is emitted without waiting. While flush is high, in_ready is 0 and the held instruction is emitted.
- R9: Output order equals input order minus the deleted stores. No instruction is lost or duplicated when out_ready is low, and out_valid and the output fields hold steady while out_valid is high and out_ready is low.
- R10: A rewritten move carries the sequence tag of the load it replaces.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Drain the held instruction; blocks input |
| in_valid | input | 1 | Input instruction valid |
| in_ready | output | 1 | Input instruction accepted this cycle |
| in_op | input | 2 | Opcode: 00 other, 01 load, 10 store, 11 move |
| in_dreg | input | REG_W | Data register (move: destination) |
| in_areg | input | REG_W | Address register (move: source) |
| in_io | input | 1 | I/O flag, disables rewriting for the pair |
| in_tag | input | TAG_W | Sequence tag |
| out_valid | output | 1 | Output instruction valid |
| out_ready | input | 1 | Downstream ready |
| out_op | output | 2 | Output opcode |
| out_dreg | output | REG_W | Output data register |
| out_areg | output | REG_W | Output address register |
| out_io | output | 1 | Output I/O flag |
| out_tag | output | TAG_W | Output sequence tag |

## Verification
Every ordered pair of opcodes is swept with the address registers equal and unequal, with the first data register equal and unequal to the address register, and with each I/O flag on and off. This separates the store-load, load-load, base-overwrite, store-store, flagged and non-pairing outcomes. Standalone held loads and held moves tell waiting apart from immediate release, and a flush with a pending input shows that flush blocks intake. A long stream over a narrow register range, with random output backpressure, produces chains of rewrites and deletions that test ordering and the absence of loss against an arithmetic model.

// File: rtl/memop_pkg.sv
package memop_pkg;
   typedef enum logic [1:0] {
      OP_OTHER = 2'b00,
      OP_LOAD  = 2'b01,
      OP_STORE = 2'b10,
      OP_MOVE  = 2'b11
   } op_e;

   function automatic logic is_memop(input logic [1:0] op);
      return (op == OP_LOAD) || (op == OP_STORE);
   endfunction
endpackage

// File: rtl/memop_pair_match.sv
module memop_pair_match
   import memop_pkg::*;
#(
   parameter int  REG_W    = 4,
   parameter int  TAG_W    = 6,
   parameter bit  EN_ST_LD = 1'b1,
   parameter bit  EN_LD_LD = 1'b1,
   parameter bit  EN_ST_ST = 1'b1
) (
   input  logic             held_vld,
   input  logic [1:0]       held_op,
   input  logic [REG_W-1:0] held_dreg,
   input  logic [REG_W-1:0] held_areg,
   input  logic             held_io,
   input  logic [1:0]       nxt_op,
   input  logic [REG_W-1:0] nxt_dreg,
   input  logic [REG_W-1:0] nxt_areg,
   input  logic             nxt_io,
   input  logic [TAG_W-1:0] nxt_tag,
   output logic             rewrite,
   output logic             drop_held,
   output logic [1:0]       rw_op,
   output logic [REG_W-1:0] rw_dreg,
   output logic [REG_W-1:0] rw_areg,
   output logic             rw_io,
   output logic [TAG_W-1:0] rw_tag
);
   logic pair_ok;
   logic st_ld_hit, ld_ld_hit, st_st_hit;

   always_comb begin
      pair_ok = held_vld && is_memop(held_op) && is_memop(nxt_op) &&
                (held_areg == nxt_areg) && !held_io && !nxt_io;
   end

   generate
      if (EN_ST_LD) begin : g_st_ld
         assign st_ld_hit = pair_ok && (held_op == OP_STORE) && (nxt_op == OP_LOAD);
      end else begin : g_no_st_ld
         assign st_ld_hit = 1'b0;
      end
      if (EN_LD_LD) begin : g_ld_ld
         assign ld_ld_hit = pair_ok && (held_op == OP_LOAD) && (nxt_op == OP_LOAD) &&
                            (held_dreg != held_areg);
      end else begin : g_no_ld_ld
         assign ld_ld_hit = 1'b0;
      end
      if (EN_ST_ST) begin : g_st_st
         assign st_st_hit = pair_ok && (held_op == OP_STORE) && (nxt_op == OP_STORE);
      end else begin : g_no_st_st
         assign st_st_hit = 1'b0;
      end
   endgenerate

   assign rewrite   = st_ld_hit || ld_ld_hit;
   assign drop_held = st_st_hit;

   always_comb begin
      if (rewrite) begin
         rw_op   = OP_MOVE;
         rw_dreg = nxt_dreg;
         rw_areg = held_dreg;
         rw_io   = 1'b0;
      end else begin
         rw_op   = nxt_op;
         rw_dreg = nxt_dreg;
         rw_areg = nxt_areg;
         rw_io   = nxt_io;
      end
      rw_tag = nxt_tag;
   end

   // R4
   always_comb begin
      if (rewrite && held_op == OP_LOAD) begin
         ld_base_chk: assert (held_dreg != nxt_areg);
      end
   end
endmodule

// File: rtl/memop_hold_slot.sv
module memop_hold_slot
   import memop_pkg::*;
#(
   parameter int REG_W = 4,
   parameter int TAG_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             in_valid,
   input  logic             drop,
   output logic             in_ready,
   input  logic [1:0]       nxt_op,
   input  logic [REG_W-1:0] nxt_dreg,
   input  logic [REG_W-1:0] nxt_areg,
   input  logic             nxt_io,
   input  logic [TAG_W-1:0] nxt_tag,
   output logic             vld,
   output logic [1:0]       h_op,
   output logic [REG_W-1:0] h_dreg,
   output logic [REG_W-1:0] h_areg,
   output logic             h_io,
   output logic [TAG_W-1:0] h_tag,
   output logic             out_valid,
   input  logic             out_ready
);
   logic vld_q;
   logic [1:0]       op_q;
   logic [REG_W-1:0] dreg_q, areg_q;
   logic             io_q;
   logic [TAG_W-1:0] tag_q;
   logic cand, take, emit;

   assign cand      = is_memop(op_q);
   assign out_valid = vld_q && !drop && (!cand || in_valid || flush);
   assign in_ready  = !flush && (!vld_q || drop || out_ready);
   assign take      = in_valid && in_ready;
   assign emit      = out_valid && out_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         op_q   <= OP_OTHER;
         dreg_q <= '0;
         areg_q <= '0;
         io_q   <= 1'b0;
         tag_q  <= '0;
      end else if (take) begin
         vld_q  <= 1'b1;
         op_q   <= nxt_op;
         dreg_q <= nxt_dreg;
         areg_q <= nxt_areg;
         io_q   <= nxt_io;
         tag_q  <= nxt_tag;
      end else if (emit) begin
         vld_q <= 1'b0;
      end
   end

   assign vld    = vld_q;
   assign h_op   = op_q;
   assign h_dreg = dreg_q;
   assign h_areg = areg_q;
   assign h_io   = io_q;
   assign h_tag  = tag_q;

   // R9
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> vld_q && $stable({op_q, dreg_q, areg_q, io_q, tag_q}));

   // R5
   drop_io_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drop |-> vld_q && !io_q && (op_q == OP_STORE));

   // R8
   flush_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush && vld_q && out_ready |=> !vld_q);
endmodule

// File: rtl/memop_peephole.sv
module memop_peephole
   import memop_pkg::*;
#(
   parameter int REG_W    = 4,
   parameter int TAG_W    = 6,
   parameter bit EN_ST_LD = 1'b1,
   parameter bit EN_LD_LD = 1'b1,
   parameter bit EN_ST_ST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [1:0]       in_op,
   input  logic [REG_W-1:0] in_dreg,
   input  logic [REG_W-1:0] in_areg,
   input  logic             in_io,
   input  logic [TAG_W-1:0] in_tag,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [1:0]       out_op,
   output logic [REG_W-1:0] out_dreg,
   output logic [REG_W-1:0] out_areg,
   output logic             out_io,
   output logic [TAG_W-1:0] out_tag
);
   generate
      if (REG_W < 1 || REG_W > 16) begin : g_bad_reg
         $error("memop_peephole: REG_W out of range");
      end
      if (TAG_W < 1 || TAG_W > 32) begin : g_bad_tag
         $error("memop_peephole: TAG_W out of range");
      end
   endgenerate

   logic             h_vld;
   logic [1:0]       h_op;
   logic [REG_W-1:0] h_dreg, h_areg;
   logic             h_io;
   logic [TAG_W-1:0] h_tag;
   logic             rewrite, drop_raw, drop_eff;
   logic [1:0]       rw_op;
   logic [REG_W-1:0] rw_dreg, rw_areg;
   logic             rw_io;
   logic [TAG_W-1:0] rw_tag;

   memop_pair_match #(
      .REG_W(REG_W), .TAG_W(TAG_W),
      .EN_ST_LD(EN_ST_LD), .EN_LD_LD(EN_LD_LD), .EN_ST_ST(EN_ST_ST)
   ) match_i (
      .held_vld (h_vld),
      .held_op  (h_op),
      .held_dreg(h_dreg),
      .held_areg(h_areg),
      .held_io  (h_io),
      .nxt_op   (in_op),
      .nxt_dreg (in_dreg),
      .nxt_areg (in_areg),
      .nxt_io   (in_io),
      .nxt_tag  (in_tag),
      .rewrite  (rewrite),
      .drop_held(drop_raw),
      .rw_op    (rw_op),
      .rw_dreg  (rw_dreg),
      .rw_areg  (rw_areg),
      .rw_io    (rw_io),
      .rw_tag   (rw_tag)
   );

   assign drop_eff = drop_raw && in_valid && !flush;

   memop_hold_slot #(.REG_W(REG_W), .TAG_W(TAG_W)) slot_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .in_valid (in_valid),
      .drop     (drop_eff),
      .in_ready (in_ready),
      .nxt_op   (rw_op),
      .nxt_dreg (rw_dreg),
      .nxt_areg (rw_areg),
      .nxt_io   (rw_io),
      .nxt_tag  (rw_tag),
      .vld      (h_vld),
      .h_op     (h_op),
      .h_dreg   (h_dreg),
      .h_areg   (h_areg),
      .h_io     (h_io),
      .h_tag    (h_tag),
      .out_valid(out_valid),
      .out_ready(out_ready)
   );

   assign out_op   = h_op;
   assign out_dreg = h_dreg;
   assign out_areg = h_areg;
   assign out_io   = h_io;
   assign out_tag  = h_tag;

   // R10
   tag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |-> rw_tag == in_tag);

   // R6
   io_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && (in_io || h_io) |-> !rewrite && !drop_eff &&
      ({rw_op, rw_dreg, rw_areg, rw_io} == {in_op, in_dreg, in_areg, in_io}));

   // R1
   reset_idle_chk: assert property (@(posedge clk)
      !rst_n |=> !out_valid);
endmodule

// File: tb/memop_peephole_tb_top.sv
module memop_peephole_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int RW = 4;
   localparam int TW = 6;
   localparam int IW = 2 + RW + RW + 1 + TW;
   localparam int MAXN = 512;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic flush = 1'b0;
   logic in_valid = 1'b0;
   logic in_ready;
   logic [1:0] in_op = '0;
   logic [RW-1:0] in_dreg = '0, in_areg = '0;
   logic in_io = 1'b0;
   logic [TW-1:0] in_tag = '0;
   logic out_valid;
   logic out_ready = 1'b1;
   logic [1:0] out_op;
   logic [RW-1:0] out_dreg, out_areg;
   logic out_io;
   logic [TW-1:0] out_tag;

   always #(CLK_PERIOD/2) clk = ~clk;

   memop_peephole #(.REG_W(RW), .TAG_W(TW)) dut_i (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .in_valid(in_valid), .in_ready(in_ready),
      .in_op(in_op), .in_dreg(in_dreg), .in_areg(in_areg), .in_io(in_io), .in_tag(in_tag),
      .out_valid(out_valid), .out_ready(out_ready),
      .out_op(out_op), .out_dreg(out_dreg), .out_areg(out_areg), .out_io(out_io), .out_tag(out_tag)
   );

   int checks = 0;
   int failures = 0;
   logic [IW-1:0] stim [0:MAXN-1];
   logic [IW-1:0] got  [0:MAXN-1];
   logic [IW-1:0] expq [0:MAXN-1];
   int ngot, nexp;

   task automatic check(input bit ok, input string req, input longint act, input longint exv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exv);
      end
   endtask

   function automatic logic [IW-1:0] mk(input logic [1:0] op, input int d, input int a,
                                        input logic io, input int tag);
      return {op, RW'(d), RW'(a), io, TW'(tag)};
   endfunction

   function automatic logic [1:0] f_op(input logic [IW-1:0] x); return x[IW-1 -: 2]; endfunction
   function automatic logic [RW-1:0] f_d(input logic [IW-1:0] x); return x[IW-3 -: RW]; endfunction
   function automatic logic [RW-1:0] f_a(input logic [IW-1:0] x); return x[TW+RW -: RW]; endfunction
   function automatic logic f_io(input logic [IW-1:0] x); return x[TW]; endfunction

   // arithmetic model of the requirements
   task automatic model(input int n);
      logic [IW-1:0] h, cur;
      bit hv;
      bit mem_h, mem_c;
      hv = 0; nexp = 0; h = '0;
      for (int i = 0; i < n; i++) begin
         cur = stim[i];
         mem_h = (f_op(h) == 2'b01) || (f_op(h) == 2'b10);
         mem_c = (f_op(cur) == 2'b01) || (f_op(cur) == 2'b10);
         if (hv && mem_h && mem_c && f_a(h) == f_a(cur) && !f_io(h) && !f_io(cur)) begin
            if (f_op(h) == 2'b10 && f_op(cur) == 2'b10) begin
               // R5: first store dropped
            end else if (f_op(cur) == 2'b01 &&
                         (f_op(h) == 2'b10 || f_d(h) != f_a(h))) begin
               expq[nexp] = h; nexp++;
               cur = {2'b11, f_d(cur), f_d(h), 1'b0, cur[TW-1:0]};
            end else begin
               expq[nexp] = h; nexp++;
            end
         end else if (hv) begin
            expq[nexp] = h; nexp++;
         end
         h = cur; hv = 1;
      end
      if (hv) begin expq[nexp] = h; nexp++; end
   endtask

   task automatic run_stream(input int n, input int rdy_pct);
      int idx = 0;
      int guard = 0;
      bit done = 0;
      ngot = 0;
      while (!done) begin
         @(posedge clk); #1;
         in_valid = (idx < n);
         if (idx < n) {in_op, in_dreg, in_areg, in_io, in_tag} = stim[idx];
         flush = (idx >= n);
         out_ready = (($urandom % 100) < rdy_pct);
         @(negedge clk);
         if (out_valid && out_ready) begin
            got[ngot] = {out_op, out_dreg, out_areg, out_io, out_tag};
            ngot++;
         end
         if (in_valid && in_ready) idx++;
         if (idx >= n && flush && !out_valid) done = 1;
         guard++;
         if (guard > 20000) begin
            check(0, "R9 stream stuck", idx, n);
            done = 1;
         end
      end
      @(posedge clk); #1;
      in_valid = 0; flush = 0; out_ready = 1;
   endtask

   task automatic compare(input int n, input string req);
      model(n);
      check(ngot == nexp, req, ngot, nexp);
      for (int k = 0; k < nexp && k < ngot; k++)
         check(got[k] == expq[k], req, got[k], expq[k]);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      string req;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1
      check(out_valid == 0, "R1 out_valid", out_valid, 0);
      check(in_ready == 1, "R1 in_ready", in_ready, 1);

      // R8: held load waits
      @(posedge clk); #1;
      {in_op, in_dreg, in_areg, in_io, in_tag} = mk(2'b01, 1, 2, 0, 5);
      in_valid = 1;
      @(posedge clk); #1;
      in_valid = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(out_valid == 0, "R8 held load waits", out_valid, 0);
      @(posedge clk); #1;
      flush = 1; in_valid = 1;
      {in_op, in_dreg, in_areg, in_io, in_tag} = mk(2'b00, 0, 0, 0, 6);
      @(negedge clk);
      check(in_ready == 0, "R8 flush blocks input", in_ready, 0);
      check(out_valid == 1 && out_tag == 5, "R8 flush drains", {out_valid, out_tag}, {1'b1, 6'd5});
      @(posedge clk); #1;
      flush = 0; in_valid = 0;
      @(negedge clk);
      check(out_valid == 0, "R8 drained", out_valid, 0);
      // R8: held move emitted without waiting
      @(posedge clk); #1;
      in_valid = 1;
      {in_op, in_dreg, in_areg, in_io, in_tag} = mk(2'b11, 3, 4, 0, 7);
      @(posedge clk); #1;
      in_valid = 0;
      @(negedge clk);
      check(out_valid == 1 && out_op == 2'b11, "R8 move not held", {out_valid, out_op}, 3'b111);
      @(posedge clk); #1;

      // exhaustive pair sweep
      for (int o1 = 0; o1 < 4; o1++)
      for (int o2 = 0; o2 < 4; o2++)
      for (int sa = 0; sa < 2; sa++)
      for (int db = 0; db < 2; db++)
      for (int i1 = 0; i1 < 2; i1++)
      for (int i2 = 0; i2 < 2; i2++) begin
         int a2;
         int d1;
         a2 = sa ? 6 : 7;
         d1 = db ? 6 : 2;
         stim[0] = mk(o1[1:0], d1, 6, i1[0], 10);
         stim[1] = mk(o2[1:0], 9, a2, i2[0], 11);
         if (i1 || i2) req = "R6";
         else if (!sa || o1 == 0 || o1 == 3 || o2 == 0 || o2 == 3) req = "R7";
         else if (o1 == 2 && o2 == 1) req = "R2";
         else if (o1 == 2 && o2 == 2) req = "R5";
         else if (o1 == 1 && o2 == 1 && db) req = "R4";
         else if (o1 == 1 && o2 == 1) req = "R3";
         else req = "R7";
         run_stream(2, 100);
         compare(2, req);
         if (req == "R2" || req == "R3") begin
            // R10
            check(ngot == 2 && got[1][TW-1:0] == 6'd11, "R10 tag kept", got[1][TW-1:0], 11);
            check(ngot == 2 && f_op(got[1]) == 2'b11, "R2 R3 move op", f_op(got[1]), 3);
         end
      end

      // R9: long stream under backpressure, narrow register range
      for (int i = 0; i < 400; i++)
         stim[i] = mk(2'($urandom % 4), int'($urandom % 4), int'($urandom % 2),
                      ($urandom % 8) == 0, i);
      run_stream(400, 60);
      compare(400, "R9");
      run_stream(400, 100);
      compare(400, "R9 full rate");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule